// File: doc/BRIEF.md
# Serial Port Interrupt Prioritizer

This block sits beside the receive and transmit paths of an asynchronous serial port. It gathers the port's event conditions and turns them into one interrupt request and an identification byte for the host. The sources are a sticky receiver line error, a receive level that has reached a programmable trigger, a stale-data timeout on the receive queue, a transmit holding register that has become empty, and changes on four active-low modem control inputs. A 4-bit enable register masks each source class. When more than one source is active, the identification byte reports the most urgent one. The host clears each source through its own side effect: reading line status, reading modem status, reading the identification register, writing transmit data, or draining or refilling the receive queue.

The block holds the enable register, the modem status register with its change flags, a queue-enable flag with a 2-bit trigger select, and an auxiliary output bit that gates the interrupt pin. Every interface is a plain control or status signal. Configuration writes and host reads are single-cycle strobes with no handshake, so there is no valid/ready stream and no back-pressure. A strobe is honoured in every cycle in which it is high.

Top module: `sio_irq_ident`

## Requirements
- R1: A write with `en_we` stores `cfg_wdata[3:0]` as the enable mask. Bit 0 enables received data and timeout, bit 1 transmit-empty, bit 2 line error and bit 3 modem change. `en_value` returns the mask in bits 3:0, with bits 7:4 always 0. The mask resets to 0.
- R2: `id_value` bit 0 is 0 while any enabled source is pending and 1 otherwise. Bits 3:1 carry the source code. Bits 5:4 are 0. Bits 7:6 both equal the queue-enable flag, which is written from `cfg_wdata[0]` by `fifo_we`. The reset value is 0x01.
- R3: The priority from highest to lowest is: line error (code 011); received data (code 010) and timeout (code 110), which share the second level with received data reported first; transmit-empty (code 001); modem change (code 000).
- R4: A `line_err` pulse sets a line-error flag that stays set until `lsr_rd`. A pulse in the same cycle as `lsr_rd` wins. The flag is reported only while enable bit 2 is set, and it survives while masked.
- R5: The received-data source is active while `rx_level` is at least the trigger count. `cfg_wdata[7:6]` on a `fifo_we` write selects the trigger: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 words.
- R6: The timeout source is active once `rx_level` is nonzero and four `char_tick` pulses have arrived with no `rx_push` or `rx_pop`. A push or pop cancels it and restarts the count. A zero level also clears the count.
- R7: The transmit-empty source is set when `thr_empty` rises, or when enable bit 1 is written from 0 to 1 while `thr_empty` is high. It is cleared by `thr_wr`, or by `id_rd` while code 001 is being reported. An `id_rd` while another code is reported leaves it set.
- R8: `msr_value` bits 7:4 show the inverted live levels of `dcd_n`, `ri_n`, `dsr_n` and `cts_n`. Bits 3, 1 and 0 are set by any change of `dcd_n`, `dsr_n` and `cts_n` respectively. Bit 2 is set only when `ri_n` goes from 0 to 1.
- R9: `msr_rd` clears all four change bits. A change sampled in the same cycle still sets its bit.
- R10: `irq` is high exactly when a source is pending and the auxiliary bit is set. The auxiliary bit is written from `cfg_wdata[0]` by `aux_we` and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wdata | input | 8 | Write data for the configuration strobes |
| en_we | input | 1 | Write the enable mask |
| fifo_we | input | 1 | Write the queue-enable flag and trigger select |
| aux_we | input | 1 | Write the auxiliary interrupt-gate bit |
| id_rd | input | 1 | Host read of the identification byte |
| lsr_rd | input | 1 | Host read of line status |
| msr_rd | input | 1 | Host read of modem status |
| thr_wr | input | 1 | Host write of transmit data |
| line_err | input | 1 | Receiver line error event pulse |
| rx_level | input | LVL_W | Words held in the receive queue |
| rx_push | input | 1 | A word arrived in the receive queue |
| rx_pop | input | 1 | The host took a word from the receive queue |
| char_tick | input | 1 | One pulse per character time |
| thr_empty | input | 1 | Transmit holding register is empty |
| dcd_n | input | 1 | Carrier detect, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dsr_n | input | 1 | Data set ready, active low |
| cts_n | input | 1 | Clear to send, active low |
| en_value | output | 8 | Enable mask readback |
| id_value | output | 8 | Identification byte |
| msr_value | output | 8 | Modem status byte |
| irq | output | 1 | Interrupt request |

## Verification
Every result here is due one clock after the edge that samples its cause. The identification byte, modem status, enable readback and `irq` are combinational views of state registered at that edge, so a strobe held across one rising edge shows its effect right after that edge. The bench drives inputs just after a falling edge and holds them across the following rising edge. It then queues its expectations at the next falling edge, where the monitor compares them before any input moves again. Multi-pulse behaviour, such as the four-tick timeout, is stepped one tick per cycle and checked after each tick, so an early or late assertion is caught in the exact cycle it happens.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  localparam int EN_W  = 4;
  localparam int NSRC  = 5;
  localparam int NLINE = 4;

  typedef enum logic [2:0] {
    CODE_MODEM = 3'b000,
    CODE_THRE  = 3'b001,
    CODE_RDA   = 3'b010,
    CODE_LSR   = 3'b011,
    CODE_CTO   = 3'b110
  } irq_code_e;

  // source index order is the priority order, index 0 most urgent
  localparam int SRC_LSR   = 0;
  localparam int SRC_RDA   = 1;
  localparam int SRC_CTO   = 2;
  localparam int SRC_THRE  = 3;
  localparam int SRC_MODEM = 4;

  function automatic irq_code_e src_code(input int idx);
    case (idx)
      SRC_LSR:  return CODE_LSR;
      SRC_RDA:  return CODE_RDA;
      SRC_CTO:  return CODE_CTO;
      SRC_THRE: return CODE_THRE;
      default:  return CODE_MODEM;
    endcase
  endfunction

  function automatic int trig_words(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/sio_modem_track.sv
module sio_modem_track #(
  parameter int            NL         = 4,
  parameter logic [NL-1:0] TRAIL_ONLY = 4'b0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] line_n,
  input  logic          clr,
  output logic [NL-1:0] samp_n,
  output logic [NL-1:0] delta
);

  for (genvar i = 0; i < NL; i++) begin : g_line
    logic hit;
    if (TRAIL_ONLY[i]) begin : g_trail
      assign hit = line_n[i] & ~samp_n[i];
    end else begin : g_any
      assign hit = line_n[i] ^ samp_n[i];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        samp_n[i] <= 1'b1;
        delta[i]  <= 1'b0;
      end else begin
        samp_n[i] <= line_n[i];
        if (hit)      delta[i] <= 1'b1;
        else if (clr) delta[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sio_rx_watch.sv
module sio_rx_watch
  import sio_irq_pkg::*;
#(
  parameter int LVL_W         = 5,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic             push,
  input  logic             pop,
  input  logic             tick,
  input  logic [1:0]       trig_sel,
  output logic             rda,
  output logic             cto
);

  localparam int CNT_W = $clog2(TIMEOUT_CHARS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT_CHARS);

  logic [CNT_W-1:0] tcnt;
  logic             empty;
  logic [LVL_W:0]   need;

  assign empty = (level == '0);
  assign need  = (LVL_W + 1)'(trig_words(trig_sel));
  assign rda   = ({1'b0, level} >= need);
  assign cto   = !empty && (tcnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt <= '0;
    end else if (empty || push || pop) begin
      tcnt <= '0;
    end else if (tick && tcnt != CNT_MAX) begin
      tcnt <= tcnt + 1'b1;
    end
  end

endmodule

// File: rtl/sio_prio_enc.sv
module sio_prio_enc
  import sio_irq_pkg::*;
(
  input  logic [NSRC-1:0] req,
  output irq_code_e       code,
  output logic            any
);

  always_comb begin
    code = CODE_MODEM;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) code = src_code(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/sio_irq_ident.sv
module sio_irq_ident
  import sio_irq_pkg::*;
#(
  parameter int LVL_W         = 5,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       cfg_wdata,
  input  logic             en_we,
  input  logic             fifo_we,
  input  logic             aux_we,
  input  logic             id_rd,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             thr_wr,
  input  logic             line_err,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  input  logic             thr_empty,
  input  logic             dcd_n,
  input  logic             ri_n,
  input  logic             dsr_n,
  input  logic             cts_n,
  output logic [7:0]       en_value,
  output logic [7:0]       id_value,
  output logic [7:0]       msr_value,
  output logic             irq
);

  logic [EN_W-1:0]  en_q;
  logic             fifo_en_q;
  logic [1:0]       trig_q;
  logic             out2_q;
  logic             line_flag;
  logic             thre_flag;
  logic             thr_q;
  logic [NLINE-1:0] modem_samp_n;
  logic [NLINE-1:0] modem_delta;
  logic             rda_raw, cto_raw;
  logic [NSRC-1:0]  req;
  irq_code_e        cur_code;
  logic             pend;
  logic             thre_set, thre_clr;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      fifo_en_q <= 1'b0;
      trig_q    <= 2'b00;
      out2_q    <= 1'b0;
    end else begin
      if (en_we)   en_q <= cfg_wdata[EN_W-1:0];
      if (fifo_we) begin
        fifo_en_q <= cfg_wdata[0];
        trig_q    <= cfg_wdata[7:6];
      end
      if (aux_we)  out2_q <= cfg_wdata[0];
    end
  end

  // sticky line error; a new event beats the clearing read
  always_ff @(posedge clk) begin
    if (!rst_n)        line_flag <= 1'b0;
    else if (line_err) line_flag <= 1'b1;
    else if (lsr_rd)   line_flag <= 1'b0;
  end

  // transmit-empty source
  assign thre_set = (thr_empty && !thr_q) ||
                    (en_we && cfg_wdata[1] && !en_q[1] && thr_empty);
  assign thre_clr = thr_wr || (id_rd && pend && cur_code == CODE_THRE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q     <= 1'b1;
      thre_flag <= 1'b0;
    end else begin
      thr_q <= thr_empty;
      if (thre_set)      thre_flag <= 1'b1;
      else if (thre_clr) thre_flag <= 1'b0;
    end
  end

  // modem lines: index 0 cts, 1 dsr, 2 ring (trailing edge only), 3 carrier
  sio_modem_track #(
    .NL         (NLINE),
    .TRAIL_ONLY (4'b0100)
  ) u_modem (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_n ({dcd_n, ri_n, dsr_n, cts_n}),
    .clr    (msr_rd),
    .samp_n (modem_samp_n),
    .delta  (modem_delta)
  );

  sio_rx_watch #(
    .LVL_W         (LVL_W),
    .TIMEOUT_CHARS (TIMEOUT_CHARS)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (rx_level),
    .push     (rx_push),
    .pop      (rx_pop),
    .tick     (char_tick),
    .trig_sel (trig_q),
    .rda      (rda_raw),
    .cto      (cto_raw)
  );

  always_comb begin
    req            = '0;
    req[SRC_LSR]   = en_q[2] && line_flag;
    req[SRC_RDA]   = en_q[0] && rda_raw;
    req[SRC_CTO]   = en_q[0] && cto_raw;
    req[SRC_THRE]  = en_q[1] && thre_flag;
    req[SRC_MODEM] = en_q[3] && (|modem_delta);
  end

  sio_prio_enc u_prio (
    .req  (req),
    .code (cur_code),
    .any  (pend)
  );

  assign en_value  = {{(8 - EN_W){1'b0}}, en_q};
  assign id_value  = {fifo_en_q, fifo_en_q, 2'b00, cur_code, !pend};
  assign msr_value = {~modem_samp_n, modem_delta};
  assign irq       = pend && out2_q;

endmodule

// File: rtl/sio_irq_ident_chk.sv
module sio_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       msr_rd,
  input logic       rx_push,
  input logic       irq,
  input logic [7:0] id_value,
  input logic [7:0] msr_value,
  input logic [3:0] modem_in_n,
  input logic [3:0] modem_samp_n,
  input logic [3:0] en_q,
  input logic       line_flag
);

  // R10: the pin never asserts without a pending source
  p_irq_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !id_value[0]);

  // R2: only defined codes appear and the reserved bits stay low
  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (id_value[3:1] != 3'b100) && (id_value[3:1] != 3'b101) &&
    (id_value[3:1] != 3'b111) && (id_value[5:4] == 2'b00));

  // R3: an enabled line error always wins
  p_lsr_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[2] && line_flag) |-> (id_value[3:1] == 3'b011));

  // R9: a modem status read with no new change empties the change bits
  p_msr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && modem_in_n == modem_samp_n) |=> (msr_value[3:0] == 4'b0000));

  // R6: an arrival cancels the timeout
  p_push_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> (id_value[3:1] != 3'b110));

  // R8: the ring flag does not appear without a low-to-high ring input
  p_ring_trail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!msr_value[2] && !(modem_in_n[2] && !modem_samp_n[2])) |=> !msr_value[2]);

endmodule

bind sio_irq_ident sio_irq_ident_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .msr_rd       (msr_rd),
  .rx_push      (rx_push),
  .irq          (irq),
  .id_value     (id_value),
  .msr_value    (msr_value),
  .modem_in_n   ({dcd_n, ri_n, dsr_n, cts_n}),
  .modem_samp_n (modem_samp_n),
  .en_q         (en_q),
  .line_flag    (line_flag)
);

// File: tb/sio_irq_ident_test.sv
module sio_irq_ident_test;

  localparam int LVL_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic en_we = 0, fifo_we = 0, aux_we = 0;
  logic id_rd = 0, lsr_rd = 0, msr_rd = 0, thr_wr = 0, line_err = 0;
  logic [LVL_W-1:0] rx_level = '0;
  logic rx_push = 0, rx_pop = 0, char_tick = 0, thr_empty = 1;
  logic dcd_n = 1, ri_n = 1, dsr_n = 1, cts_n = 1;
  logic [7:0] en_value, id_value, msr_value;
  logic irq;

  always #10 clk = ~clk;

  sio_irq_ident #(.LVL_W(LVL_W), .TIMEOUT_CHARS(4)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wdata(cfg_wdata), .en_we(en_we),
    .fifo_we(fifo_we), .aux_we(aux_we), .id_rd(id_rd), .lsr_rd(lsr_rd),
    .msr_rd(msr_rd), .thr_wr(thr_wr), .line_err(line_err),
    .rx_level(rx_level), .rx_push(rx_push), .rx_pop(rx_pop),
    .char_tick(char_tick), .thr_empty(thr_empty), .dcd_n(dcd_n),
    .ri_n(ri_n), .dsr_n(dsr_n), .cts_n(cts_n), .en_value(en_value),
    .id_value(id_value), .msr_value(msr_value), .irq(irq)
  );

  typedef struct {
    int         sel;   // 0 id, 1 msr, 2 enable, 3 irq
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // monitor: compares queued expectations against the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.sel)
          0: act = id_value;
          1: act = msr_value;
          2: act = en_value;
          default: act = {7'b0, irq};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input int sel, input logic [7:0] exp, input string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic flush();
    -> chk_ev;
    #1;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      char_tick = 1; cyc(); char_tick = 0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    // reset state
    expect_val(0, 8'h01, "R2"); expect_val(1, 8'h00, "R8");
    expect_val(2, 8'h00, "R1"); expect_val(3, 8'h00, "R10");
    flush();

    // R1 mask, R7 enable-while-empty, R10 gate closed
    cfg_wdata = 8'hFF; en_we = 1; cyc(); en_we = 0;
    expect_val(2, 8'h0F, "R1"); expect_val(0, 8'h02, "R7"); expect_val(3, 8'h00, "R10");
    flush();
    cfg_wdata = 8'h01; aux_we = 1; cyc(); aux_we = 0;
    expect_val(3, 8'h01, "R10"); flush();
    id_rd = 1; cyc(); id_rd = 0;
    expect_val(0, 8'h01, "R7"); expect_val(3, 8'h00, "R10"); flush();

    // R4 line error, R3 over modem change, R9 clear
    line_err = 1; cyc(); line_err = 0;
    expect_val(0, 8'h06, "R4"); flush();
    cts_n = 0; cyc();
    expect_val(0, 8'h06, "R3"); expect_val(1, 8'h11, "R8"); flush();
    lsr_rd = 1; cyc(); lsr_rd = 0;
    expect_val(0, 8'h00, "R4"); expect_val(3, 8'h01, "R10"); flush();
    msr_rd = 1; cyc(); msr_rd = 0;
    expect_val(1, 8'h10, "R9"); expect_val(0, 8'h01, "R9"); flush();

    // R8 ring trailing edge only
    ri_n = 0; cyc();
    expect_val(1, 8'h50, "R8"); expect_val(0, 8'h01, "R8"); flush();
    ri_n = 1; cyc();
    expect_val(1, 8'h14, "R8"); expect_val(0, 8'h00, "R8"); flush();
    msr_rd = 1; cyc(); msr_rd = 0;
    expect_val(1, 8'h10, "R9"); flush();

    // R8 carrier, R9 change during read
    dcd_n = 0; cyc();
    expect_val(1, 8'h98, "R8"); flush();
    msr_rd = 1; dsr_n = 0; cyc(); msr_rd = 0;
    expect_val(1, 8'hB2, "R9"); flush();
    msr_rd = 1; cyc(); msr_rd = 0;
    expect_val(1, 8'hB0, "R9"); flush();
    dcd_n = 1; dsr_n = 1; cts_n = 1; cyc();
    expect_val(1, 8'h0B, "R8"); flush();
    msr_rd = 1; cyc(); msr_rd = 0;
    expect_val(1, 8'h00, "R9"); expect_val(0, 8'h01, "R9"); flush();

    // R5 trigger levels, R2 queue-enable bits
    cfg_wdata = 8'h41; fifo_we = 1; cyc(); fifo_we = 0;
    expect_val(0, 8'hC1, "R2"); flush();
    rx_level = 3; cyc(); expect_val(0, 8'hC1, "R5"); flush();
    rx_level = 4; cyc(); expect_val(0, 8'hC4, "R5"); flush();
    cfg_wdata = 8'h81; fifo_we = 1; cyc(); fifo_we = 0;
    expect_val(0, 8'hC1, "R5"); flush();
    rx_level = 8; cyc(); expect_val(0, 8'hC4, "R5"); flush();
    cfg_wdata = 8'hC1; fifo_we = 1; rx_level = 13; cyc(); fifo_we = 0;
    expect_val(0, 8'hC1, "R5"); flush();
    rx_level = 14; cyc(); expect_val(0, 8'hC4, "R5"); flush();
    cfg_wdata = 8'h01; fifo_we = 1; rx_level = 1; cyc(); fifo_we = 0;
    expect_val(0, 8'hC4, "R5"); flush();
    rx_level = 0; cyc(); expect_val(0, 8'hC1, "R5"); flush();

    // R6 timeout
    cfg_wdata = 8'hC1; fifo_we = 1; rx_level = 2; cyc(); fifo_we = 0;
    ticks(3); expect_val(0, 8'hC1, "R6"); flush();
    ticks(1); expect_val(0, 8'hCC, "R6"); flush();
    rx_level = 14; cyc(); expect_val(0, 8'hC4, "R3"); flush();
    rx_level = 2; cyc(); expect_val(0, 8'hCC, "R6"); flush();
    rx_pop = 1; cyc(); rx_pop = 0;
    expect_val(0, 8'hC1, "R6"); flush();
    ticks(4); expect_val(0, 8'hCC, "R6"); flush();
    rx_push = 1; cyc(); rx_push = 0;
    expect_val(0, 8'hC1, "R6"); flush();
    ticks(3);
    rx_level = 0; ticks(1);
    rx_level = 2; ticks(1);
    expect_val(0, 8'hC1, "R6"); flush();
    rx_level = 0; cyc();

    // R7 transmit-empty
    thr_empty = 0; cyc(); thr_empty = 1; cyc();
    expect_val(0, 8'hC2, "R7"); flush();
    thr_wr = 1; cyc(); thr_wr = 0;
    expect_val(0, 8'hC1, "R7"); flush();
    thr_empty = 0; cyc(); thr_empty = 1; cyc();
    line_err = 1; cyc(); line_err = 0;
    expect_val(0, 8'hC6, "R3"); flush();
    id_rd = 1; cyc(); id_rd = 0;
    lsr_rd = 1; cyc(); lsr_rd = 0;
    expect_val(0, 8'hC2, "R7"); flush();
    cts_n = 0; cyc();
    expect_val(0, 8'hC2, "R3"); flush();
    id_rd = 1; cyc(); id_rd = 0;
    expect_val(0, 8'hC0, "R3"); flush();
    msr_rd = 1; cyc(); msr_rd = 0;
    expect_val(0, 8'hC1, "R9"); flush();

    // R4 masked but sticky, R10 gate
    cfg_wdata = 8'h00; en_we = 1; cyc(); en_we = 0;
    line_err = 1; cyc(); line_err = 0;
    expect_val(0, 8'hC1, "R4"); expect_val(3, 8'h00, "R4"); flush();
    cfg_wdata = 8'h04; en_we = 1; cyc(); en_we = 0;
    expect_val(0, 8'hC6, "R4"); expect_val(3, 8'h01, "R10"); flush();
    cfg_wdata = 8'h00; aux_we = 1; cyc(); aux_we = 0;
    expect_val(3, 8'h00, "R10"); expect_val(0, 8'hC6, "R10"); flush();
    lsr_rd = 1; cyc(); lsr_rd = 0;
    expect_val(0, 8'hC1, "R4"); flush();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule